// File: doc/BRIEF.md
# Incremental Delta-Sigma Decimator

This block is the digital back end of a one-shot (incremental) delta-sigma converter. A start pulse clears every digital integrator. The same pulse makes the block issue a one-cycle reset request that clears the modulator's analog integrators. The block then takes exactly `NCYC` valid modulator bits, where each bit stands for +1 or -1. It passes them through a chain of `ORDER` digital integrators and ends with a single signed result and a one-cycle done flag.

The chain order, from one to three, is fixed at elaboration. The first order gives the classic charge-balancing count. Higher orders match a higher-order modulator loop, or shorten settling for a first-order loop. Each stage is wide enough to hold `NCYC^ORDER` without wrap. A new start during a conversion abandons that conversion and begins again. The result register keeps its value until the next conversion completes.

Top module: `incr_ds_decim`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mod_rst_o` are 0 and `result_o` is 0.
- R2: A high `conv_start_i` sampled at a clock edge drives `mod_rst_o` high for exactly the following cycle and sets `busy_o`. `mod_rst_o` is never high at any other time.
- R3: Each accepted modulator bit is taken as +1 when 1 and as -1 when 0. With ORDER=1 the result is (number of ones) minus (number of zeros) over the conversion.
- R4: With order k, the result equals the sum over accepted bits i = 1..N of d_i * C(N-i+k-1, k-1). Here d_i is +1 or -1 and C is the binomial coefficient. Each stage adds the freshly updated value of the stage before it.
- R5: A conversion accepts exactly NCYC bits. `done_o` is high for one cycle, the cycle after the NCYC-th accepted bit. `busy_o` falls in that same cycle.
- R6: A bit presented with `mod_vld_i` low during a conversion changes neither the result nor the number of bits counted.
- R7: Bits presented while idle, valid or not, leave `result_o` unchanged, raise no `done_o`, and do not affect the next conversion.
- R8: A start during a conversion discards the partial conversion and raises no `done_o` for it. It pulses `mod_rst_o` again, and the result reflects only bits accepted after the new start.
- R9: `result_o` changes only in the cycle in which `done_o` is high. It holds through the whole of the following conversion.
- R10: Full-scale inputs of all ones and all zeros give +C(N+k-1, k) and -C(N+k-1, k) exactly, with no overflow, in two's complement.
- R11: A valid bit presented in the same cycle as the start is not accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Begin (or restart) a conversion |
| mod_bit_i | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| mod_vld_i | input | 1 | Qualifies `mod_bit_i` |
| mod_rst_o | output | 1 | One-cycle clear request to the analog loop integrators |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe: `result_o` has just been updated |
| result_o | output | ORDER*clog2(NCYC+1)+1 | Signed conversion result |

## Verification
The bench builds two instances with NCYC=16. Both take the same stimulus. One has ORDER=3 and the other ORDER=1. The short conversion makes each vector cheap, so full-scale extremes, alternating and skewed patterns, and gap patterns can all be run in a single pass. Running both orders at once tests the plain up/down count and the binomially weighted three-stage sum against the same bits. It also exposes any mistake in the chaining between stages or in the stage widths at the boundary of the 16-bit result.

// File: rtl/incr_ds_pkg.sv
package incr_ds_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } conv_state_e;

  // Maps a modulator bit onto a two-bit signed step of +1 or -1.
  function automatic logic signed [1:0] bip_step(input logic b);
    return b ? 2'sd1 : -2'sd1;
  endfunction

  // Adds one integrator input to its running value.
  function automatic logic [63:0] integ_add(input logic [63:0] acc, input logic [63:0] inc);
    return acc + inc;
  endfunction

  // Binomial coefficient, evaluated at elaboration for bound checks.
  function automatic longint binom(input int n, input int k);
    longint r;
    r = 1;
    for (int i = 1; i <= k; i++) r = (r * longint'(n - k + i)) / longint'(i);
    return r;
  endfunction

endpackage

// File: rtl/incr_ds_seq.sv
module incr_ds_seq
  import incr_ds_pkg::*;
#(
  parameter int NCYC = 256,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          vld_i,
  output logic          clr_o,
  output logic          acc_en_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          modrst_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST_IDX = CW'(NCYC - 1);

  conv_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          modrst_q;
  logic          run_w;

  assign run_w    = (st_q == ST_RUN);
  assign clr_o    = start_i;
  assign acc_en_o = run_w && vld_i && !start_i;
  assign last_o   = acc_en_o && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      modrst_q <= 1'b0;
    end else begin
      done_q   <= last_o;
      modrst_q <= start_i;
      if (start_i) begin
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else if (last_o) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (acc_en_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = run_w;
  assign done_o   = done_q;
  assign modrst_o = modrst_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/incr_ds_integ.sv
module incr_ds_integ
  import incr_ds_pkg::*;
#(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] sum_q;
  logic [63:0]  wide_w;

  assign wide_w = integ_add(64'(sum_q), 64'(add_i));
  assign nxt_o  = wide_w[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (en_i)  sum_q <= nxt_o;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/incr_ds_decim.sv
module incr_ds_decim
  import incr_ds_pkg::*;
#(
  parameter  int ORDER = 2,
  parameter  int NCYC  = 256,
  localparam int LOGN  = $clog2(NCYC + 1),
  localparam int ACC_W = ORDER * LOGN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_i,
  input  logic             mod_bit_i,
  input  logic             mod_vld_i,
  output logic             mod_rst_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ACC_W-1:0] result_o
);

  localparam int CW = LOGN;

  // Named internal events, brought out for the bound checker.
  logic                         clr_w;
  logic                         acc_en_w;
  logic                         last_w;
  logic [CW-1:0]                cnt_w;
  logic signed [1:0]            step_w;
  logic [ORDER-1:0][ACC_W-1:0]  add_w;
  logic [ORDER-1:0][ACC_W-1:0]  nxt_w;
  logic [ORDER-1:0][ACC_W-1:0]  sum_w;
  logic [ORDER*ACC_W-1:0]       state_flat_w;
  logic [ACC_W-1:0]             result_q;

  incr_ds_seq #(
    .NCYC (NCYC),
    .CW   (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (conv_start_i),
    .vld_i    (mod_vld_i),
    .clr_o    (clr_w),
    .acc_en_o (acc_en_w),
    .last_o   (last_w),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .modrst_o (mod_rst_o),
    .cnt_o    (cnt_w)
  );

  assign step_w = bip_step(mod_bit_i);

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign add_w[k] = {{(ACC_W-2){step_w[1]}}, step_w};
    end else begin : g_chain
      assign add_w[k] = nxt_w[k-1];
    end

    incr_ds_integ #(
      .W (ACC_W)
    ) u_integ (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_w),
      .en_i  (acc_en_w),
      .add_i (add_w[k]),
      .nxt_o (nxt_w[k]),
      .sum_o (sum_w[k])
    );
  end

  assign state_flat_w = sum_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (last_w) result_q <= nxt_w[ORDER-1];
  end

  assign result_o = result_q;

endmodule

// File: rtl/incr_ds_decim_chk.sv
module incr_ds_decim_chk
  import incr_ds_pkg::*;
#(
  parameter int ORDER = 2,
  parameter int NCYC  = 256,
  parameter int ACC_W = 19,
  parameter int CW    = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   mod_rst,
  input logic                   busy,
  input logic                   done,
  input logic                   acc_en,
  input logic                   clr,
  input logic [CW-1:0]          cnt,
  input logic [ORDER*ACC_W-1:0] state,
  input logic [ACC_W-1:0]       result
);

  localparam longint MAXV = binom(NCYC + ORDER - 1, ORDER);

  AST_MODRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> mod_rst); // R2
  AST_MODRST_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n) mod_rst |-> $past(start)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(busy) && !busy)); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) < NCYC); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R9
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!acc_en && !clr) |=> $stable(state)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (longint'($signed(result)) <= MAXV && longint'($signed(result)) >= -MAXV)); // R10

endmodule

bind incr_ds_decim incr_ds_decim_chk #(
  .ORDER (ORDER),
  .NCYC  (NCYC),
  .ACC_W (ACC_W),
  .CW    (CW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (conv_start_i),
  .mod_rst (mod_rst_o),
  .busy    (busy_o),
  .done    (done_o),
  .acc_en  (acc_en_w),
  .clr     (clr_w),
  .cnt     (cnt_w),
  .state   (state_flat_w),
  .result  (result_o)
);

// File: tb/incr_ds_decim_test.sv
`timescale 1ns/1ps
module incr_ds_decim_test;

  localparam int N   = 16;
  localparam int W3  = 3 * $clog2(N + 1) + 1;
  localparam int W1  = 1 * $clog2(N + 1) + 1;
  localparam int NV  = 8;

  localparam logic [15:0] VBITS [NV] = '{16'hFFFF, 16'h0000, 16'h5555, 16'hAAAA,
                                         16'h00FF, 16'hFF00, 16'h1234, 16'h8001};
  localparam logic [15:0] VGAPS [NV] = '{16'h0000, 16'h0F0F, 16'h0000, 16'h8421,
                                         16'h0000, 16'hFFFF, 16'h0001, 16'h3000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mbit = 1'b0;
  logic mvld = 1'b0;
  logic mrst3, busy3, done3, mrst1, busy1, done1;
  logic signed [W3-1:0] res3;
  logic signed [W1-1:0] res1;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  incr_ds_decim #(.ORDER(3), .NCYC(N)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .mod_bit_i(mbit), .mod_vld_i(mvld),
    .mod_rst_o(mrst3), .busy_o(busy3), .done_o(done3), .result_o(res3));

  incr_ds_decim #(.ORDER(1), .NCYC(N)) uut_o1 (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .mod_bit_i(mbit), .mod_vld_i(mvld),
    .mod_rst_o(mrst1), .busy_o(busy1), .done_o(done1), .result_o(res1));

  function automatic longint choose(input int n, input int k);
    longint num = 1, den = 1;
    for (int i = 0; i < k; i++) begin
      num = num * longint'(n - i);
      den = den * longint'(i + 1);
    end
    return num / den;
  endfunction

  // Weighted sum of bipolar bits for an order-k chain, first bit at index 0.
  function automatic longint expect_val(input int k, input logic [15:0] bits);
    longint s = 0;
    for (int i = 1; i <= N; i++) begin
      longint d = bits[i-1] ? 1 : -1;
      s += d * choose(N - i + k - 1, k - 1);
    end
    return s;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic with_bit);
    @(negedge clk);
    start = 1'b1;
    mvld = with_bit;
    mbit = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mvld = 1'b0;
    chk("R2 mod_rst pulse", longint'(mrst3 & mrst1), 1);
    chk("R2 busy set", longint'(busy3 & busy1), 1);
  endtask

  // Feeds count bits; a set gap bit inserts one invalid cycle before the bit.
  task automatic feed(input logic [15:0] bits, input logic [15:0] gaps, input int count,
                      input longint hold3, input longint hold1);
    for (int i = 0; i < count; i++) begin
      if (i == count - 1) begin
        chk("R9 result held in run", longint'(res3), hold3);
        chk("R9 result held in run o1", longint'(res1), hold1);
      end
      chk("R5 no early done", longint'(done3 | done1), 0);
      if (gaps[i]) begin
        mvld = 1'b0;
        mbit = ~bits[i];
        @(negedge clk);
      end
      mvld = 1'b1;
      mbit = bits[i];
      @(negedge clk);
    end
    mvld = 1'b0;
  endtask

  task automatic conv(input logic [15:0] bits, input logic [15:0] gaps, input string tag);
    longint h3, h1;
    h3 = longint'(res3);
    h1 = longint'(res1);
    pulse_start(1'b0);
    feed(bits, gaps, N, h3, h1);
    chk({tag, " R5 done"}, longint'(done3 & done1), 1);
    chk({tag, " R5 busy drop"}, longint'(busy3 | busy1), 0);
    chk({tag, " R4 order3"}, longint'(res3), expect_val(3, bits));
    chk({tag, " R3 order1"}, longint'(res1), expect_val(1, bits));
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, longint'(done3 | done1), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", longint'(busy3 | busy1), 0);
    chk("R1 done", longint'(done3 | done1), 0);
    chk("R1 mod_rst", longint'(mrst3 | mrst1), 0);
    chk("R1 result", longint'(res3) + longint'(res1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 no mod_rst without start", longint'(mrst3 | mrst1), 0);

    // Table walk: R3, R4, R6 (gaps), R10 (entries 0 and 1)
    for (int v = 0; v < NV; v++) conv(VBITS[v], VGAPS[v], $sformatf("vec%0d", v));
    conv(16'hFFFF, 16'h0000, "R10 full+");
    chk("R10 max order3", longint'(res3), choose(N + 2, 3));
    conv(16'h0000, 16'h0000, "R10 full-");
    chk("R10 min order1", longint'(res1), -longint'(N));

    // R7: valid bits while idle
    for (int i = 0; i < 5; i++) begin
      mvld = 1'b1;
      mbit = i[0];
      @(negedge clk);
      chk("R7 idle result", longint'(res3), -choose(N + 2, 3));
      chk("R7 idle no done", longint'(done3 | done1), 0);
    end
    mvld = 1'b0;
    conv(16'hC3A5, 16'h0000, "R7 after idle");

    // R11: bit valid together with start is dropped
    pulse_start(1'b1);
    feed(16'h0000, 16'h0000, N, expect_val(3, 16'hC3A5), expect_val(1, 16'hC3A5));
    chk("R11 done", longint'(done1), 1);
    chk("R11 order1", longint'(res1), -longint'(N));
    chk("R11 order3", longint'(res3), expect_val(3, 16'h0000));
    @(negedge clk);

    // R8: restart mid conversion
    pulse_start(1'b0);
    feed(16'hFFFF, 16'h0000, 7, -choose(N + 2, 3), -longint'(N));
    chk("R8 no done for aborted", longint'(done3 | done1), 0);
    pulse_start(1'b0);
    feed(16'h0F0F, 16'h0101, N, -choose(N + 2, 3), -longint'(N));
    chk("R8 done", longint'(done3), 1);
    chk("R8 order3", longint'(res3), expect_val(3, 16'h0F0F));
    chk("R8 order1", longint'(res1), expect_val(1, 16'h0F0F));
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule